// File: doc/BRIEF.md
# Manchester II Serial Word Receiver

This block takes the two rails of a bipolar receive line, with a clock running at a fixed multiple of the bit rate. It finds the three-bit-time sync that opens a word and tells the two sync kinds apart. It then recovers sixteen data bits and one parity bit and hands the finished word, in parallel, to a receive buffer. A positive rail alone means the line is at its positive level. A negative rail alone means the negative level. Equal rails mean the line is idle.

Each rail passes through a two-flop synchronizer. A run-length counter measures how long the line has held each symbol. The controller has three states:

- `ST_HUNT` looks for a sync.
- `ST_SYNC_TAIL` times the second half of the sync.
- `ST_BITS` samples each bit at one quarter and at three quarters of its period.

The transitions are:

- **HUNT→SYNC_TAIL**: a valid level run of 1.5 bit times, within tolerance, flips to the opposite level.
- **SYNC_TAIL→HUNT**: the line is not at the tail level at the middle of the tail.
- **SYNC_TAIL→BITS**: the tail ends.
- **BITS→HUNT**: a bad bit is found, or the parity bit has been evaluated.

Top module: `mdec_word_rx`

## Requirements
- R1: After reset, `word_valid`, `manch_err`, `word_par_err`, `word_is_cmd` and `word_data` are all 0. They stay 0 while the line is idle.
- R2: A positive run of 1.5 bit times followed by a negative run of 1.5 bit times is a command sync. The word that follows is reported with `word_is_cmd` = 1.
- R3: A negative run of 1.5 bit times followed by a positive run is a data sync. The word that follows is reported with `word_is_cmd` = 0.
- R4: The first half of the sync is accepted when its length is 1.5·SPB ± SYNC_TOL samples. With the defaults (SPB=8, SYNC_TOL=1), 11 to 13 samples are accepted, and runs of 10 or 14 samples produce no output.
- R5: A bit is 1 when its first half is positive and its second half negative, and 0 for the reverse. The first data bit received lands in `word_data[15]`, and the last data bit lands in `word_data[0]`.
- R6: The parity bit follows the 16 data bits. `word_par_err` is 1, together with `word_valid`, when the 17 bits hold an even number of ones. The word is still presented in that case.
- R7: `word_valid` is a one-cycle pulse. It comes 1.5·SPB + 16·SPB + 3·SPB/4 + 3 clock cycles after the first sample of the sync's second half is applied at the pins (149 cycles at the defaults).
- R8: When a bit, including the parity bit, has the same level in both half-bit samples, `manch_err` pulses for one cycle and no word is presented. For bit index i (0 = first data bit, 16 = parity), the pulse comes 1.5·SPB + i·SPB + 3·SPB/4 + 3 cycles after the first sample of the sync tail.
- R9: When the line is idle at either half-bit sample inside a word, the block reports the same error with the same timing as R8.
- R10: `word_valid` and `manch_err` are never high in the same cycle. `word_data` changes only in a cycle where `word_valid` is high.
- R11: After an aborted word or a rejected sync, the block is back in sync search, and the next well-formed word is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, SPB cycles per bit |
| rst_n | input | 1 | Active-low reset |
| rx_pos | input | 1 | Positive rail of the receive line (asynchronous) |
| rx_neg | input | 1 | Negative rail of the receive line (asynchronous) |
| word_valid | output | 1 | One-cycle strobe: a word is complete |
| word_data | output | 16 | Received word, first bit in the MSB |
| word_is_cmd | output | 1 | Sync kind of the presented word: 1 command, 0 data |
| word_par_err | output | 1 | Parity check failed, valid with `word_valid` |
| manch_err | output | 1 | One-cycle pulse: word aborted on a bad bit |

## Verification
A wrong phase or bit counter moves the `word_valid` or `manch_err` pulse off its exact cycle, so it is seen at most one bit time after the fault. Every such pulse is compared against a cycle-exact expected schedule. A wrong sync classification or bit order shows in `word_is_cmd` or `word_data` on the very strobe of the affected word. A controller that fails to return to search shows as a missing strobe on the clean word sent right after each abort or rejected sync.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    // Line symbol built from {positive rail, negative rail}
    typedef enum logic [1:0] {
        SYM_IDLE_N = 2'b00,
        SYM_LO     = 2'b01,
        SYM_HI     = 2'b10,
        SYM_IDLE_B = 2'b11
    } mdec_sym_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_SYNC_TAIL,
        ST_BITS
    } mdec_state_e;

    localparam int unsigned WORD_BITS = 16;

    function automatic logic sym_is_level(input mdec_sym_e s);
        return (s == SYM_LO) || (s == SYM_HI);
    endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_rail
        logic meta_q;
        logic safe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                safe_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                safe_q <= meta_q;
            end
        end
        assign q_o[g] = safe_q;
    end
endmodule

// File: rtl/mdec_runlen.sv
module mdec_runlen import mdec_pkg::*; #(
    parameter int unsigned RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mdec_sym_e        sym_i,
    output mdec_sym_e        sym_d_o,
    output logic             flip_o,
    output logic [RUN_W-1:0] run_o
);
    localparam logic [RUN_W-1:0] RUN_SAT = '1;

    mdec_sym_e        prev_q;
    logic [RUN_W-1:0] cnt_q;

    assign flip_o  = (sym_i != prev_q);
    assign sym_d_o = prev_q;
    assign run_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= SYM_IDLE_N;
            cnt_q  <= '0;
        end else begin
            prev_q <= sym_i;
            if (flip_o) begin
                cnt_q <= RUN_W'(1);
            end else if (cnt_q != RUN_SAT) begin
                cnt_q <= cnt_q + RUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdec_shift.sv
module mdec_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (shift_en) begin
            data_o <= {data_o[W-2:0], din};
        end
    end
endmodule

// File: rtl/mdec_word_rx.sv
module mdec_word_rx import mdec_pkg::*; #(
    parameter int unsigned SPB      = 8,
    parameter int unsigned SYNC_TOL = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_pos,
    input  logic                 rx_neg,
    output logic                 word_valid,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_is_cmd,
    output logic                 word_par_err,
    output logic                 manch_err
);
    localparam int unsigned HALF_SYNC = (3 * SPB) / 2;
    localparam int unsigned Q1        = SPB / 4;
    localparam int unsigned Q3        = (3 * SPB) / 4;
    localparam int unsigned TICK_W    = $clog2(HALF_SYNC);
    localparam int unsigned RUN_W     = $clog2(HALF_SYNC + SYNC_TOL + 2);
    localparam int unsigned NBIT_W    = $clog2(WORD_BITS + 1);
    localparam int unsigned RUN_MIN   = HALF_SYNC - SYNC_TOL;
    localparam int unsigned RUN_MAX   = HALF_SYNC + SYNC_TOL;

    logic [1:0]           rails_s;
    mdec_sym_e            sym;
    mdec_sym_e            sym_d;
    logic                 flip;
    logic [RUN_W-1:0]     run_len;
    mdec_state_e          state_q, state_d;
    logic [TICK_W-1:0]    tick_q;
    logic [NBIT_W-1:0]    nbit_q;
    mdec_sym_e            h1_q;
    logic                 cmd_q;
    logic [WORD_BITS-1:0] shreg;

    mdec_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rx_pos, rx_neg}),
        .q_o   (rails_s)
    );

    assign sym = mdec_sym_e'(rails_s);

    mdec_runlen #(.RUN_W(RUN_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_i   (sym),
        .sym_d_o (sym_d),
        .flip_o  (flip),
        .run_o   (run_len)
    );

    // ---------------- control decode ----------------
    logic      in_window, sync_seen, tail_bad, tail_end;
    logic      bit_eval, bit_bad, last_bit, word_done, at_q1;
    mdec_sym_e tail_level;

    assign in_window  = (run_len >= RUN_W'(RUN_MIN)) && (run_len <= RUN_W'(RUN_MAX));
    assign sync_seen  = (state_q == ST_HUNT) && flip && sym_is_level(sym_d)
                        && sym_is_level(sym) && in_window;
    assign tail_level = cmd_q ? SYM_LO : SYM_HI;
    assign tail_bad   = (state_q == ST_SYNC_TAIL) && (tick_q == TICK_W'(HALF_SYNC / 2))
                        && (sym != tail_level);
    assign tail_end   = (state_q == ST_SYNC_TAIL) && (tick_q == TICK_W'(HALF_SYNC - 1));
    assign at_q1      = (state_q == ST_BITS) && (tick_q == TICK_W'(Q1));
    assign bit_eval   = (state_q == ST_BITS) && (tick_q == TICK_W'(Q3));
    assign bit_bad    = !sym_is_level(h1_q) || !sym_is_level(sym) || (sym == h1_q);
    assign last_bit   = (nbit_q == NBIT_W'(WORD_BITS));
    assign word_done  = bit_eval && !bit_bad && last_bit;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sync_seen) state_d = ST_SYNC_TAIL;
            end
            ST_SYNC_TAIL: begin
                if (tail_bad)      state_d = ST_HUNT;
                else if (tail_end) state_d = ST_BITS;
            end
            ST_BITS: begin
                if (bit_eval && (bit_bad || last_bit)) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // ---------------- timing counters and capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            nbit_q <= '0;
            h1_q   <= SYM_IDLE_N;
            cmd_q  <= 1'b0;
        end else begin
            if (sync_seen) begin
                tick_q <= TICK_W'(1);
                nbit_q <= '0;
                cmd_q  <= (sym_d == SYM_HI);
            end else if (state_q == ST_SYNC_TAIL) begin
                tick_q <= tail_end ? '0 : tick_q + TICK_W'(1);
            end else if (state_q == ST_BITS) begin
                tick_q <= (tick_q == TICK_W'(SPB - 1)) ? '0 : tick_q + TICK_W'(1);
                if (at_q1) h1_q <= sym;
                if (bit_eval && !bit_bad) nbit_q <= nbit_q + NBIT_W'(1);
            end
        end
    end

    mdec_shift #(.W(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_eval && !bit_bad && !last_bit),
        .din      (h1_q == SYM_HI),
        .data_o   (shreg)
    );

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid   <= 1'b0;
            word_data    <= '0;
            word_is_cmd  <= 1'b0;
            word_par_err <= 1'b0;
            manch_err    <= 1'b0;
        end else begin
            word_valid   <= word_done;
            manch_err    <= bit_eval && bit_bad;
            word_par_err <= word_done && !((^shreg) ^ (h1_q == SYM_HI));
            if (word_done) begin
                word_data   <= shreg;
                word_is_cmd <= cmd_q;
            end
        end
    end

endmodule

// File: rtl/mdec_word_rx_chk.sv
module mdec_word_rx_chk import mdec_pkg::*; (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 word_valid,
    input logic                 word_par_err,
    input logic                 manch_err,
    input logic [WORD_BITS-1:0] word_data
);
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        manch_err |=> !manch_err);

    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_valid && manch_err));

    assert_parerr_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_par_err |-> word_valid);

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_data));

    assert_abort_no_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        manch_err |=> !word_valid);
endmodule

bind mdec_word_rx mdec_word_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .word_par_err (word_par_err),
    .manch_err    (manch_err),
    .word_data    (word_data)
);

// File: tb/mdec_word_rx_tb.sv
module mdec_word_rx_tb;
    import mdec_pkg::*;

    localparam int SPB  = 8;
    localparam int HALF = 12;
    localparam int Q3   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pos = 1'b0;
    logic        rx_neg = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        word_is_cmd;
    logic        word_par_err;
    logic        manch_err;

    mdec_word_rx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_pos       (rx_pos),
        .rx_neg       (rx_neg),
        .word_valid   (word_valid),
        .word_data    (word_data),
        .word_is_cmd  (word_is_cmd),
        .word_par_err (word_par_err),
        .manch_err    (manch_err)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          at;
        bit          is_word;
        logic [15:0] data;
        bit          cmd;
        bit          perr;
        string       tag;
    } ev_t;

    ev_t   evq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    mon_on = 1'b0;

    // Reference comparison on every clock, away from the active edge
    always @(negedge clk) begin : mon
        ev_t   e;
        bit    ew;
        bit    ee;
        string tg;
        ew = 1'b0;
        ee = 1'b0;
        tg = cur_req;
        if (mon_on) begin
            if (evq.size() > 0 && evq[0].at == cyc) begin
                e  = evq.pop_front();
                ew = e.is_word;
                ee = !e.is_word;
                tg = e.tag;
            end
            n_chk++;
            if (word_valid !== ew) begin
                n_fail++;
                $display("FAIL %s word_valid at cycle %0d: actual %b expected %b", tg, cyc, word_valid, ew);
            end
            n_chk++;
            if (manch_err !== ee) begin
                n_fail++;
                $display("FAIL %s manch_err at cycle %0d: actual %b expected %b", tg, cyc, manch_err, ee);
            end
            n_chk++;
            if (word_valid && manch_err) begin
                n_fail++;
                $display("FAIL R10 exclusive at cycle %0d: actual 11 expected not both", cyc);
            end
            if (ew && word_valid) begin
                n_chk++;
                if (word_data !== e.data) begin
                    n_fail++;
                    $display("FAIL %s R5 data: actual %h expected %h", tg, word_data, e.data);
                end
                n_chk++;
                if (word_is_cmd !== e.cmd) begin
                    n_fail++;
                    $display("FAIL %s sync kind: actual %b expected %b", tg, word_is_cmd, e.cmd);
                end
                n_chk++;
                if (word_par_err !== e.perr) begin
                    n_fail++;
                    $display("FAIL %s R6 parity flag: actual %b expected %b", tg, word_par_err, e.perr);
                end
            end
        end
    end

    task automatic slot(input logic p, input logic n);
        @(negedge clk);
        rx_pos = p;
        rx_neg = n;
    endtask

    task automatic lvl(input bit hi);
        slot(hi, !hi);
    endtask

    task automatic idle(input int k);
        repeat (k) slot(1'b0, 1'b0);
    endtask

    // bad_kind: 0 none, 1 same level both halves, 2 idle
    task automatic send(input bit cmd, input int l1, input logic [15:0] d, input bit bad_par,
                        input int bad_idx, input int bad_kind, input bit expect_sync,
                        input string tag);
        logic [16:0] w;
        int          e_at;
        ev_t         ev;
        w = {d, (~^d) ^ bad_par};
        repeat (l1) lvl(cmd);
        lvl(!cmd);
        e_at = cyc;
        if (expect_sync) begin
            ev.data = d;
            ev.cmd  = cmd;
            ev.tag  = tag;
            if (bad_idx >= 0) begin
                ev.at      = e_at + HALF + bad_idx * SPB + Q3 + 3;
                ev.is_word = 1'b0;
                ev.perr    = 1'b0;
            end else begin
                ev.at      = e_at + HALF + 16 * SPB + Q3 + 3;
                ev.is_word = 1'b1;
                ev.perr    = bad_par;
            end
            evq.push_back(ev);
        end
        repeat (HALF - 1) lvl(!cmd);
        for (int i = 0; i < 17; i++) begin
            if (i == bad_idx) begin
                if (bad_kind == 1) repeat (SPB) lvl(1'b1);
                else idle(SPB);
                break;
            end
            repeat (SPB / 2) lvl(w[16-i]);
            repeat (SPB / 2) lvl(!w[16-i]);
        end
        idle(20);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual cycle %0d expected finish earlier", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if ({word_valid, manch_err, word_par_err, word_is_cmd, word_data} !== 20'h0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %b expected 0",
                     {word_valid, manch_err, word_par_err, word_is_cmd, word_data});
        end
        mon_on = 1'b1;
        cur_req = "R1";
        idle(15);

        cur_req = "R2";
        send(1'b1, 12, 16'hA5C3, 1'b0, -1, 0, 1'b1, "R2,R7");
        cur_req = "R3";
        send(1'b0, 12, 16'h1234, 1'b0, -1, 0, 1'b1, "R3,R7");
        cur_req = "R5";
        send(1'b1, 12, 16'h8001, 1'b0, -1, 0, 1'b1, "R5");
        send(1'b0, 12, 16'hFFFF, 1'b0, -1, 0, 1'b1, "R5");
        send(1'b1, 12, 16'h0000, 1'b0, -1, 0, 1'b1, "R5");
        cur_req = "R6";
        send(1'b1, 12, 16'h00FF, 1'b1, -1, 0, 1'b1, "R6");
        send(1'b0, 12, 16'h7FFE, 1'b1, -1, 0, 1'b1, "R6");
        cur_req = "R4";
        send(1'b1, 11, 16'h4C2D, 1'b0, -1, 0, 1'b1, "R4");
        send(1'b0, 13, 16'h3B5A, 1'b0, -1, 0, 1'b1, "R4");
        send(1'b1, 10, 16'h2222, 1'b0, -1, 0, 1'b0, "R4");
        send(1'b0, 14, 16'h9111, 1'b0, -1, 0, 1'b0, "R4");
        cur_req = "R11";
        send(1'b1, 12, 16'h6E01, 1'b0, -1, 0, 1'b1, "R11");
        cur_req = "R8";
        send(1'b1, 12, 16'hC3A5, 1'b0, 5, 1, 1'b1, "R8");
        send(1'b0, 12, 16'h5555, 1'b0, 16, 1, 1'b1, "R8");
        cur_req = "R11";
        send(1'b0, 12, 16'hD00D, 1'b0, -1, 0, 1'b1, "R11");
        cur_req = "R9";
        send(1'b1, 12, 16'h0F0F, 1'b0, 9, 2, 1'b1, "R9");
        cur_req = "R11";
        send(1'b0, 12, 16'hBEEF, 1'b1, -1, 0, 1'b1, "R11");
        idle(30);

        n_chk++;
        if (evq.size() != 0) begin
            n_fail++;
            $display("FAIL R11 pending events: actual %0d expected 0", evq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule